// File: doc/BRIEF.md
# Display Control Register Unit

This unit is the control-port side of a display processor. It takes 32-bit control words, each carrying an 8-bit command number in its top byte. It keeps a bank of shadow copies of the low-numbered commands and maintains a 32-bit status word. From the horizontal span, the vertical span and the video-mode command it works out the visible picture size. It also answers information queries by loading a read-back word. That word is picked from the drawing setting registers, which a neighbouring command parser owns and this unit only reads.

The width is the horizontal span, counted in units of 1/2560 of a scan line, scaled by the horizontal resolution of the current mode. This needs a division by 2560, which runs in a multi-cycle sequential divider. While a size result is being worked out, a valid flag is held low. The height is the vertical span, doubled when the double-height mode bit is set. A zero or negative result falls back to the vertical resolution of the mode.

Top module: `dispctl_unit`

## Requirements
- R1: The command number is `wr_data[31:24]`. A write whose command is in 0x01..0x0F and whose full 32-bit word equals the stored shadow copy for that command has no effect: the status word and read-back word stay unchanged, and `size_valid` does not drop. Commands 0x00 and 0x10 and above are never ignored this way.
- R2: Both `rst` and command 0x00 do the following. They load the status word with 0x14802000 and clear the read-back word. They set display start to (0,0) and both spans to zero, and set the size to 256 x 240 with `size_valid` high. They clear all shadow copies except the copy for command 0x03, which becomes 1.
- R3: Command 0x03 copies data bit 0 into status bit 23 (blanking).
- R4: Command 0x04 copies data bits 1:0 into status bits 30:29 (DMA direction).
- R5: Command 0x05 sets `disp_x` from data bits 9:0 and `disp_y` from data bits 19:10.
- R6: Command 0x06 sets the left edge from data bits 11:0 and the right edge from data bits 23:12. With span = right − left: if span ≤ 0 or span ≥ 2560, the width equals the horizontal resolution. Otherwise the width equals floor(span × hres / 2560).
- R7: Command 0x07 sets the top line from data bits 9:0 and the bottom line from data bits 19:10. The height is bottom − top, doubled when status bit 19 is set. If that is ≤ 0, the height equals the vertical resolution.
- R8: Command 0x08 writes data bits 5:0 into status bits 22:17 and data bit 6 into status bit 16, leaving all other status bits alone. It then recomputes both width and height.
- R9: Status bits 18:16 pick hres from 256, 368, 320, 384, 512, 512, 640, 640 (index 0..7). Status bits 20:19 pick vres from 240, 480, 256, 480 (index 0..3).
- R10: Commands 0x10..0x1F load `rd_word` one cycle later, based on data bits 3:0. Values 2..5 give `set_regs[data[2:0]]` ANDed with 0x000FFFFF. Value 6 gives `set_regs[5]` ANDed with 0x000FFFFF. Value 7 gives 2. Any other value gives 0.
- R11: `size_valid` is low from the first cycle after an accepted write of 0x06, 0x07 or 0x08 until the new size is on `disp_w` and `disp_h`. An accepted write made while a divide is running restarts the width calculation from the register values current after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Control word present this cycle |
| wr_data | input | 32 | Control word, command in bits 31:24 |
| set_regs | input | 256 | Eight 32-bit drawing setting registers, read only |
| rd_word | output | 32 | Read-back word loaded by info queries |
| status_word | output | 32 | Status word |
| disp_x | output | 10 | Display start X |
| disp_y | output | 10 | Display start Y |
| disp_w | output | 12 | Effective display width |
| disp_h | output | 12 | Effective display height |
| size_valid | output | 1 | Width and height are up to date |

## Verification
The assertions assume a few things about the inputs. Each control word is presented for a single cycle and stands alone. `set_regs` is steady in the cycle a query is written. Commands above 0x1F carry no meaning. The stimulus meets these by holding the setting registers constant for the whole run. It sends words one per call with an idle cycle between them, except in the single back-to-back pair that deliberately hits a running divide. Between size-changing writes it waits for `size_valid`, so every width result is sampled only after the divide has settled.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

    localparam int X_W   = 12;
    localparam int Y_W   = 10;
    localparam int POS_W = 10;
    localparam int RES_W = 10;

    localparam logic [31:0] STATUS_INIT = 32'h1480_2000;

    localparam int BLANK_BIT   = 23;
    localparam int DMA_LO      = 29;
    localparam int MODE_LO     = 16;
    localparam int DHEIGHT_BIT = 19;

    localparam logic [7:0] CMD_RESET  = 8'h00;
    localparam logic [7:0] CMD_BLANK  = 8'h03;
    localparam logic [7:0] CMD_DMA    = 8'h04;
    localparam logic [7:0] CMD_START  = 8'h05;
    localparam logic [7:0] CMD_HSPAN  = 8'h06;
    localparam logic [7:0] CMD_VSPAN  = 8'h07;
    localparam logic [7:0] CMD_MODE   = 8'h08;
    localparam logic [3:0] CMD_INFO_HI = 4'h1;

    typedef struct packed {
        logic [POS_W-1:0] y;
        logic [POS_W-1:0] x;
    } disp_start_t;

    typedef struct packed {
        logic [X_W-1:0] right;
        logic [X_W-1:0] left;
    } hspan_t;

    typedef struct packed {
        logic [Y_W-1:0] bottom;
        logic [Y_W-1:0] top;
    } vspan_t;

    function automatic logic [RES_W-1:0] hres_of(input logic [2:0] idx);
        case (idx)
            3'd0:    return RES_W'(256);
            3'd1:    return RES_W'(368);
            3'd2:    return RES_W'(320);
            3'd3:    return RES_W'(384);
            3'd4,
            3'd5:    return RES_W'(512);
            default: return RES_W'(640);
        endcase
    endfunction

    function automatic logic [RES_W-1:0] vres_of(input logic [1:0] idx);
        case (idx)
            2'd0:    return RES_W'(240);
            2'd2:    return RES_W'(256);
            default: return RES_W'(480);
        endcase
    endfunction

endpackage

// File: rtl/dispctl_shadow.sv
module dispctl_shadow #(
    parameter int NUM_SHADOW = 16,
    parameter int ONE_IDX    = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    output logic        wr_accept
);
    localparam int IDX_W = $clog2(NUM_SHADOW);

    logic [NUM_SHADOW-1:0][31:0] bank_q;
    logic [7:0]       cmd;
    logic             in_bank;
    logic             same;
    logic [IDX_W-1:0] idx;

    always_comb begin
        cmd     = wr_data[31:24];
        in_bank = (32'(cmd) < NUM_SHADOW);
        idx     = cmd[IDX_W-1:0];
        same    = in_bank && (cmd != 8'h00) && (bank_q[idx] == wr_data);
        wr_accept = wr_valid && !same;
    end

    always_ff @(posedge clk) begin
        if (rst || (wr_accept && cmd == 8'h00)) begin
            for (int i = 0; i < NUM_SHADOW; i++) begin
                bank_q[i] <= (i == ONE_IDX) ? 32'd1 : 32'd0;
            end
        end else if (wr_accept && in_bank) begin
            bank_q[idx] <= wr_data;
        end
    end

endmodule

// File: rtl/dispctl_divider.sv
module dispctl_divider #(
    parameter int NUM_W  = 22,
    parameter int DEN_W  = 12,
    parameter int DENOM  = 2560,
    parameter int QUOT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic [NUM_W-1:0]  numer,
    output logic              busy,
    output logic [QUOT_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0]  num_q;
    logic [DEN_W-1:0]  rem_q;
    logic [QUOT_W-1:0] quo_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              busy_q;

    logic [DEN_W:0]    trial;
    logic [DEN_W:0]    diff;
    logic              fits;
    logic [DEN_W-1:0]  rem_nx;

    always_comb begin
        trial  = {rem_q, num_q[NUM_W-1]};
        fits   = (trial >= (DEN_W+1)'(DENOM));
        diff   = trial - (DEN_W+1)'(DENOM);
        rem_nx = fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            num_q  <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(NUM_W);
            num_q  <= numer;
            rem_q  <= '0;
            quo_q  <= '0;
        end else if (busy_q) begin
            num_q <= num_q << 1;
            rem_q <= rem_nx;
            quo_q <= (quo_q << 1) | QUOT_W'(fits);
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy = busy_q;
    assign quot = quo_q;

endmodule

// File: rtl/dispctl_info.sv
module dispctl_info #(
    parameter int NUM_SET = 8,
    parameter int INFO_W  = 20
) (
    input  logic [3:0]               sel,
    input  logic [NUM_SET-1:0][31:0] set_regs,
    output logic [31:0]              word
);
    localparam logic [31:0] MASK = 32'((64'd1 << INFO_W) - 1);

    always_comb begin
        case (sel)
            4'h2, 4'h3, 4'h4, 4'h5: word = set_regs[sel[2:0]] & MASK;
            4'h6:                   word = set_regs[5] & MASK;
            4'h7:                   word = 32'd2;
            default:                word = 32'd0;
        endcase
    end

endmodule

// File: rtl/dispctl_unit.sv
module dispctl_unit
    import dispctl_pkg::*;
#(
    parameter int NUM_SHADOW = 16,
    parameter int NUM_SET    = 8,
    parameter int SPAN_UNITS = 2560,
    parameter int SIZE_W     = 12,
    parameter int INFO_W     = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_valid,
    input  logic [31:0]              wr_data,
    input  logic [NUM_SET-1:0][31:0] set_regs,
    output logic [31:0]              rd_word,
    output logic [31:0]              status_word,
    output logic [POS_W-1:0]         disp_x,
    output logic [POS_W-1:0]         disp_y,
    output logic [SIZE_W-1:0]        disp_w,
    output logic [SIZE_W-1:0]        disp_h,
    output logic                     size_valid
);
    localparam int PROD_W = X_W + RES_W;
    localparam int DEN_W  = $clog2(SPAN_UNITS + 1);

    logic        wr_accept;
    logic [7:0]  cmd;
    logic        is_reset;

    logic [31:0]  status_q;
    logic [31:0]  rd_q;
    disp_start_t  start_q;
    hspan_t       hs_q;
    vspan_t       vs_q;
    logic [SIZE_W-1:0] w_q;
    logic [SIZE_W-1:0] h_q;
    logic         from_div_q;
    logic         pend_w_q;
    logic         pend_h_q;

    logic signed [X_W:0]   hspan;
    logic                  w_full;
    logic [RES_W-1:0]      hres_cur;
    logic [RES_W-1:0]      vres_cur;
    logic [PROD_W-1:0]     prod;
    logic signed [Y_W+2:0] vdiff;
    logic signed [Y_W+2:0] vspan;
    logic [SIZE_W-1:0]     h_calc;

    logic              div_start;
    logic              div_abort;
    logic              div_busy;
    logic [SIZE_W-1:0] div_quot;
    logic [31:0]       info_word;

    assign cmd      = wr_data[31:24];
    assign is_reset = wr_accept && (cmd == CMD_RESET);

    dispctl_shadow #(
        .NUM_SHADOW (NUM_SHADOW),
        .ONE_IDX    (int'(CMD_BLANK))
    ) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .wr_accept (wr_accept)
    );

    dispctl_info #(
        .NUM_SET (NUM_SET),
        .INFO_W  (INFO_W)
    ) u_info (
        .sel      (wr_data[3:0]),
        .set_regs (set_regs),
        .word     (info_word)
    );

    // Width: span against the current horizontal resolution
    always_comb begin
        hspan    = $signed({1'b0, hs_q.right}) - $signed({1'b0, hs_q.left});
        w_full   = (hspan <= 0) || (hspan >= SPAN_UNITS);
        hres_cur = hres_of(status_q[MODE_LO+2:MODE_LO]);
        prod     = PROD_W'(hspan[X_W-1:0]) * PROD_W'(hres_cur);
    end

    // Height: span, doubled in double-height mode, else mode fallback
    always_comb begin
        vres_cur = vres_of(status_q[MODE_LO+4:MODE_LO+3]);
        vdiff    = $signed({3'b000, vs_q.bottom}) - $signed({3'b000, vs_q.top});
        vspan    = status_q[DHEIGHT_BIT] ? (vdiff <<< 1) : vdiff;
        if (vspan <= 0) begin
            h_calc = SIZE_W'(vres_cur);
        end else begin
            h_calc = vspan[SIZE_W-1:0];
        end
    end

    assign div_start = pend_w_q && !w_full && !is_reset;
    assign div_abort = is_reset;

    dispctl_divider #(
        .NUM_W  (PROD_W),
        .DEN_W  (DEN_W),
        .DENOM  (SPAN_UNITS),
        .QUOT_W (SIZE_W)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .abort (div_abort),
        .numer (prod),
        .busy  (div_busy),
        .quot  (div_quot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q   <= STATUS_INIT;
            rd_q       <= '0;
            start_q    <= '0;
            hs_q       <= '0;
            vs_q       <= '0;
            w_q        <= SIZE_W'(256);
            h_q        <= SIZE_W'(240);
            from_div_q <= 1'b0;
            pend_w_q   <= 1'b0;
            pend_h_q   <= 1'b0;
        end else begin
            if (pend_w_q) begin
                pend_w_q <= 1'b0;
                if (w_full) begin
                    w_q        <= SIZE_W'(hres_cur);
                    from_div_q <= 1'b0;
                end else begin
                    from_div_q <= 1'b1;
                end
            end
            if (pend_h_q) begin
                pend_h_q <= 1'b0;
                h_q      <= h_calc;
            end
            if (wr_accept) begin
                if (div_busy) begin
                    pend_w_q <= 1'b1;
                end
                if (cmd[7:4] == CMD_INFO_HI) begin
                    rd_q <= info_word;
                end
                case (cmd)
                    CMD_RESET: begin
                        status_q   <= STATUS_INIT;
                        rd_q       <= '0;
                        start_q    <= '0;
                        hs_q       <= '0;
                        vs_q       <= '0;
                        w_q        <= SIZE_W'(256);
                        h_q        <= SIZE_W'(240);
                        from_div_q <= 1'b0;
                        pend_w_q   <= 1'b0;
                        pend_h_q   <= 1'b0;
                    end
                    CMD_BLANK: status_q[BLANK_BIT] <= wr_data[0];
                    CMD_DMA:   status_q[DMA_LO+1:DMA_LO] <= wr_data[1:0];
                    CMD_START: begin
                        start_q.x <= wr_data[POS_W-1:0];
                        start_q.y <= wr_data[2*POS_W-1:POS_W];
                    end
                    CMD_HSPAN: begin
                        hs_q.left  <= wr_data[X_W-1:0];
                        hs_q.right <= wr_data[2*X_W-1:X_W];
                        pend_w_q   <= 1'b1;
                    end
                    CMD_VSPAN: begin
                        vs_q.top    <= wr_data[Y_W-1:0];
                        vs_q.bottom <= wr_data[2*Y_W-1:Y_W];
                        pend_h_q    <= 1'b1;
                    end
                    CMD_MODE: begin
                        status_q[MODE_LO+6:MODE_LO] <= {wr_data[5:0], wr_data[6]};
                        pend_w_q <= 1'b1;
                        pend_h_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_word     = rd_q;
    assign status_word = status_q;
    assign disp_x      = start_q.x;
    assign disp_y      = start_q.y;
    assign disp_w      = from_div_q ? div_quot : w_q;
    assign disp_h      = h_q;
    assign size_valid  = !pend_w_q && !pend_h_q && !div_busy;

endmodule

// File: rtl/dispctl_unit_chk.sv
module dispctl_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_valid,
    input logic [31:0] wr_data,
    input logic        wr_accept,
    input logic [31:0] status_word,
    input logic [31:0] rd_word,
    input logic [11:0] disp_w,
    input logic        size_valid
);
    // R1
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_accept) |=> ($stable(status_word) && $stable(rd_word)));

    // R2
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_accept && wr_data[31:24] == 8'h00) |=>
            (status_word == 32'h1480_2000 && rd_word == 32'd0 && disp_w == 12'd256 && size_valid));

    // R3
    blank_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_accept && wr_data[31:24] == 8'h03) |=> (status_word[23] == $past(wr_data[0])));

    // R8
    mode_field_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_accept && wr_data[31:24] == 8'h08) |=>
            (status_word[22:16] == {$past(wr_data[5:0]), $past(wr_data[6])}));

    // R10
    info_const_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_data[31:28] == 4'h1 && wr_data[3:0] == 4'h7) |=> (rd_word == 32'd2));

    // R11
    size_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_accept && (wr_data[31:24] == 8'h06 || wr_data[31:24] == 8'h07)) |=> !size_valid);

    // R6
    width_bound_chk: assert property (@(posedge clk) disable iff (rst)
        size_valid |-> (disp_w <= 12'd640));

endmodule

bind dispctl_unit dispctl_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .wr_accept   (wr_accept),
    .status_word (status_word),
    .rd_word     (rd_word),
    .disp_w      (disp_w),
    .size_valid  (size_valid)
);

// File: tb/dispctl_unit_test.sv
module dispctl_unit_test;

    typedef struct packed {
        logic [31:0] data;
        logic [31:0] st;
        logic [11:0] w;
        logic [11:0] h;
    } vec_t;

    // Status / size walk starting from the reset state (R3, R4, R8, R9)
    localparam vec_t VEC [7] = '{
        '{32'h0300_0000, 32'h1400_2000, 12'd256, 12'd240},
        '{32'h0400_0002, 32'h5400_2000, 12'd256, 12'd240},
        '{32'h0400_0001, 32'h3400_2000, 12'd256, 12'd240},
        '{32'h0800_0001, 32'h3402_2000, 12'd320, 12'd240},
        '{32'h0800_0040, 32'h3401_2000, 12'd368, 12'd240},
        '{32'h0800_007F, 32'h347F_2000, 12'd640, 12'd480},
        '{32'h0300_0001, 32'h34FF_2000, 12'd640, 12'd480}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_valid = 1'b0;
    logic [31:0]       wr_data = '0;
    logic [7:0][31:0]  set_regs;
    logic [31:0]       rd_word;
    logic [31:0]       status_word;
    logic [9:0]        disp_x;
    logic [9:0]        disp_y;
    logic [11:0]       disp_w;
    logic [11:0]       disp_h;
    logic              size_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dispctl_unit uut (
        .clk         (clk),
        .rst         (rst),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .set_regs    (set_regs),
        .rd_word     (rd_word),
        .status_word (status_word),
        .disp_x      (disp_x),
        .disp_y      (disp_y),
        .disp_w      (disp_w),
        .disp_h      (disp_h),
        .size_valid  (size_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
        wr_data  = '0;
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 200; i++) begin
            if (size_valid) break;
            @(negedge clk);
        end
        chk("R11 size_valid returns", 32'(size_valid), 32'd1);
    endtask

    function automatic logic [31:0] setval(input int i);
        return 32'hA500_0000 | (32'(i) * 32'h0001_1111);
    endfunction

    initial begin
        for (int i = 0; i < 8; i++) set_regs[i] = setval(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        chk("R2 status", status_word, 32'h1480_2000);
        chk("R2 rd_word", rd_word, 32'd0);
        chk("R2 width", 32'(disp_w), 32'd256);
        chk("R2 height", 32'(disp_h), 32'd240);
        chk("R2 valid", 32'(size_valid), 32'd1);
        chk("R2 start", {12'd0, disp_y, disp_x}, 32'd0);

        // table walk
        for (int k = 0; k < 7; k++) begin
            wr(VEC[k].data);
            wait_valid();
            chk("R3/R4/R8 status", status_word, VEC[k].st);
            chk("R9 width", 32'(disp_w), 32'(VEC[k].w));
            chk("R9 height", 32'(disp_h), 32'(VEC[k].h));
        end

        // R2 soft reset via command, and never ignored
        wr(32'h0000_0000);
        chk("R2 cmd status", status_word, 32'h1480_2000);
        chk("R2 cmd width", 32'(disp_w), 32'd256);
        chk("R2 cmd height", 32'(disp_h), 32'd480 - 32'd240);
        wr(32'h0300_0000);
        chk("R3 blank clear", status_word, 32'h1400_2000);
        wr(32'h0000_0000);
        chk("R1 repeated reset applies", status_word, 32'h1480_2000);

        // R5 display start
        wr(32'h050A_A955);
        chk("R5 x", 32'(disp_x), 32'h155);
        chk("R5 y", 32'(disp_y), 32'h2AA);

        // R6 with hres 256: span 1000 -> 100
        wr(32'h063E_8000);
        chk("R11 drop after span write", 32'(size_valid), 32'd0);
        wait_valid();
        chk("R6 span1000 hres256", 32'(disp_w), 32'd100);

        // hres 640
        wr(32'h0800_0003);
        wait_valid();
        chk("R6 mode640 width", 32'(disp_w), 32'd250);
        wr(32'h06C5_F260);
        wait_valid();
        chk("R6 span2559", 32'(disp_w), 32'd639);
        wr(32'h06C6_0260);
        wait_valid();
        chk("R6 span2560 full", 32'(disp_w), 32'd640);
        wr(32'h0626_0260);
        wait_valid();
        chk("R6 span0 full", 32'(disp_w), 32'd640);
        wr(32'h0610_0260);
        wait_valid();
        chk("R6 negative span full", 32'(disp_w), 32'd640);
        wr(32'h0650_0000);
        wait_valid();
        chk("R6 span1280", 32'(disp_w), 32'd320);

        // R1 repeat of identical word is ignored
        wr(32'h0650_0000);
        chk("R1 repeat keeps valid", 32'(size_valid), 32'd1);
        chk("R1 repeat keeps width", 32'(disp_w), 32'd320);

        // R11 restart: back-to-back span writes
        @(negedge clk);
        wr_valid = 1'b1; wr_data = 32'h0640_0000;
        @(negedge clk);
        wr_data = 32'h0620_0000;
        @(negedge clk);
        wr_valid = 1'b0; wr_data = '0;
        repeat (6) @(negedge clk);
        wr(32'h0400_0002);
        wait_valid();
        chk("R11 restart result", 32'(disp_w), 32'd128);

        // R7 height
        wr(32'h0704_0010);
        wait_valid();
        chk("R7 plain height", 32'(disp_h), 32'd240);
        wr(32'h0800_0007);
        wait_valid();
        chk("R7 double height", 32'(disp_h), 32'd480);
        chk("R8 width kept", 32'(disp_w), 32'd128);
        wr(32'h0700_0410);
        wait_valid();
        chk("R7 negative fallback", 32'(disp_h), 32'd480);

        // R10 info queries
        wr(32'h1000_0002);
        chk("R10 sel2", rd_word, setval(2) & 32'h000F_FFFF);
        wr(32'h1000_0005);
        chk("R10 sel5", rd_word, setval(5) & 32'h000F_FFFF);
        wr(32'h1A00_0006);
        chk("R10 sel6", rd_word, setval(5) & 32'h000F_FFFF);
        wr(32'h1F00_0007);
        chk("R10 sel7", rd_word, 32'd2);
        wr(32'h1000_0012);
        chk("R10 sel2 high bits", rd_word, setval(2) & 32'h000F_FFFF);
        wr(32'h1000_000A);
        chk("R10 other", rd_word, 32'd0);
        wr(32'h1000_0004);
        wr(32'h1000_0001);
        chk("R10 sel1", rd_word, 32'd0);
        wr(32'h1000_0003);
        wr(32'h0000_0000);
        chk("R2 clears rd_word", rd_word, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule